// File: doc/BRIEF.md
# Pen Scan Trigger

This block takes the level-sensitive, active-low pen-down interrupt of a resistive touch controller and produces a paced series of single-cycle scan triggers for a separate scan sequencer. When the interrupt is seen while it is unmasked, the block masks it and fires a trigger. It then waits for the sequencer's scan-done pulse. After that it holds off for the programmed scan interval minus the measured scan duration, and then re-arms. While the pen stays down, each re-arm leads straight to the next trigger, so the rate of scans never exceeds one per interval. A typical interval is 10000 us, which gives roughly a hundred scans per second.

At each re-arm that follows a scan caused by the pen, a one-shot timer is started. Its length is the interval rounded up to whole milliseconds. If the pen is lifted, this timer produces one trailing scan so that the release can be observed. The re-arm after that trailing scan starts no timer, so the block goes quiet until the pen touches again. A global enable gates the whole block. Time is measured in microsecond steps derived from the clock by a parameterised prescaler, and every wait restarts its prescaler at the moment it is started.

Top module: `pen_scan_trigger`

## Requirements
- R1: After reset `irq_masked` is 1 and `scan_trig` is 0, and while `enable` is 0 no trigger is issued whatever `pen_irq_n` does.
- R2: One clock after `enable` goes to 1, `irq_masked` falls. One clock after `enable` goes to 0, `irq_masked` rises and any pending one-shot timer is cancelled, so re-enabling produces no trailing trigger.
- R3: When `pen_irq_n` falls while unmasked, `scan_trig` is high in the third cycle after the change (two synchronizer stages plus one register), and `irq_masked` is 1 in that same cycle.
- R4: A low level on `pen_irq_n` that comes and goes while the interrupt is masked is discarded. No trigger comes from it after the next re-arm.
- R5: For a `scan_done` pulse accepted at clock edge P: if `scan_interval_us` > `scan_time_us`, `irq_masked` falls after edge P + CLKS_PER_US*(interval-time)+1. Otherwise it falls right after edge P. A `scan_done` received while no scan is outstanding has no effect.
- R6: At a re-arm that follows a pen-caused scan, a one-shot timer of E = max(1, ceil(interval/US_PER_MS))*US_PER_MS microseconds starts. If no pen interrupt occurs, `scan_trig` rises CLKS_PER_US*E+1 cycles after the edge at which the block was unmasked.
- R7: At a re-arm that follows a timer-caused scan, no timer is started, and no trigger occurs until the next pen interrupt.
- R8: A pen trigger cancels a pending one-shot timer and clears the extra-trigger count. The next re-arm therefore starts a fresh full-length timer, timed from that re-arm.
- R9: While `pen_irq_n` is held low, every re-arm is followed by a trigger on the very next cycle.
- R10: `scan_trig` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global enable for triggering |
| pen_irq_n | input | 1 | Pen-down interrupt, active low, asynchronous |
| scan_done | input | 1 | Single-cycle pulse from the scan sequencer when a scan finishes |
| scan_interval_us | input | TIME_W | Target time between scans, in microseconds |
| scan_time_us | input | TIME_W | Measured duration of one scan, in microseconds |
| scan_trig | output | 1 | Single-cycle pulse that starts a scan |
| irq_masked | output | 1 | 1 while the pen interrupt is masked |

## Verification
Every result has a fixed latency. A pen edge becomes a trigger after three cycles. A settle wait ends CLKS_PER_US*(interval-time)+1 cycles after the accepted scan-done edge, or right after that edge when the difference is not positive. A one-shot tail arrives CLKS_PER_US*E+1 cycles after the unmasking edge. A held pen retriggers one cycle after unmasking. The bench drives its inputs and samples the outputs on the falling clock edge. It counts falling edges from each stimulus to the first change it observes, and compares that count with the value its own functions compute from the programmed interval and scan time. Both values are drawn at random within bounded ranges across several rounds, with directed cases for a zero interval and a non-positive difference.

// File: rtl/pst_pkg.sv
package pst_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_ARMED = 2'd1,
      ST_SCAN  = 2'd2,
      ST_HOLD  = 2'd3
   } pst_state_e;
endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic active
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], din_n};
   end

   assign active = ~sr[STAGES-1];
endmodule

// File: rtl/pst_timer.sv
module pst_timer #(
   parameter int CLKS_PER_US = 100,
   parameter int US_PER_MS   = 1000,
   parameter int W           = 16,
   parameter bit ROUND_MS    = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         cancel,
   input  logic [W-1:0] dur_us,
   output logic         expire
);
   localparam int EW = W + 1;
   localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

   logic          busy;
   logic [CW-1:0] cyc;
   logic [EW-1:0] elapsed;
   logic [EW-1:0] e_nx;
   logic [W-1:0]  dur_q;
   logic          us_tick;
   logic          ms_edge;
   logic          done;

   assign us_tick = busy && (cyc == CW'(CLKS_PER_US - 1));
   assign e_nx    = elapsed + EW'(1);

   generate
      if (ROUND_MS) begin : g_round
         localparam int PW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
         logic [PW-1:0] phase;
         assign ms_edge = (phase == PW'(US_PER_MS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                phase <= '0;
            else if (cancel || load)   phase <= '0;
            else if (us_tick)          phase <= ms_edge ? '0 : phase + PW'(1);
         end
      end else begin : g_exact
         assign ms_edge = 1'b1;
      end
   endgenerate

   assign done = us_tick && ms_edge && (e_nx >= {1'b0, dur_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cyc     <= '0;
         elapsed <= '0;
         dur_q   <= '0;
         expire  <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (cancel) begin
            busy <= 1'b0;
         end else if (load) begin
            busy    <= 1'b1;
            cyc     <= '0;
            elapsed <= '0;
            dur_q   <= dur_us;
         end else if (busy) begin
            if (us_tick) begin
               cyc     <= '0;
               elapsed <= e_nx;
               if (done) begin
                  busy   <= 1'b0;
                  expire <= 1'b1;
               end
            end else begin
               cyc <= cyc + CW'(1);
            end
         end
      end
   end

   // R6: an expiry ends the countdown and lasts one cycle
   a_r6_expire_idle: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> !busy);
   a_r6_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
   import pst_pkg::*;
#(
   parameter int XCNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pen_act,
   input  logic scan_done,
   input  logic settle_pos,
   input  logic settle_exp,
   input  logic osh_exp,
   output logic settle_load,
   output logic settle_cancel,
   output logic osh_load,
   output logic osh_cancel,
   output logic scan_trig,
   output logic irq_masked
);
   pst_state_e        state, state_nx;
   logic [XCNT_W-1:0] xcnt;
   logic              trig_nx;
   logic              cnt_clr;
   logic              cnt_inc;
   logic              rearm;

   always_comb begin
      state_nx      = state;
      trig_nx       = 1'b0;
      settle_load   = 1'b0;
      settle_cancel = 1'b0;
      osh_cancel    = 1'b0;
      cnt_clr       = 1'b0;
      cnt_inc       = 1'b0;
      rearm         = 1'b0;
      if (!enable) begin
         state_nx      = ST_OFF;
         settle_cancel = 1'b1;
         osh_cancel    = 1'b1;
      end else begin
         unique case (state)
            ST_OFF:   state_nx = ST_ARMED;
            ST_ARMED: begin
               if (pen_act) begin
                  osh_cancel = 1'b1;
                  cnt_clr    = 1'b1;
                  trig_nx    = 1'b1;
                  state_nx   = ST_SCAN;
               end else if (osh_exp) begin
                  cnt_inc  = 1'b1;
                  trig_nx  = 1'b1;
                  state_nx = ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (scan_done) begin
                  if (settle_pos) begin
                     settle_load = 1'b1;
                     state_nx    = ST_HOLD;
                  end else begin
                     rearm = 1'b1;
                  end
               end
            end
            ST_HOLD:  if (settle_exp) rearm = 1'b1;
            default:  state_nx = ST_OFF;
         endcase
         if (rearm) state_nx = ST_ARMED;
      end
   end

   assign osh_load   = rearm && (xcnt == '0);
   assign irq_masked = (state != ST_ARMED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_OFF;
         scan_trig <= 1'b0;
         xcnt      <= '0;
      end else begin
         state     <= state_nx;
         scan_trig <= trig_nx;
         if (cnt_clr)                     xcnt <= '0;
         else if (cnt_inc && xcnt != '1)  xcnt <= xcnt + XCNT_W'(1);
      end
   end

   // R10: trigger is a single-cycle pulse
   a_r10_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig |=> !scan_trig);
   // R3: interrupt is masked while the trigger is out
   a_r3_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig |-> irq_masked);
   // R4: triggers only come from the unmasked state
   a_r4_trig_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig |-> $past(state) == ST_ARMED);
   // R2: disabling masks one cycle later
   a_r2_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> irq_masked);
endmodule

// File: rtl/pen_scan_trigger.sv
module pen_scan_trigger #(
   parameter int CLKS_PER_US = 100,
   parameter int US_PER_MS   = 1000,
   parameter int TIME_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int XCNT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              pen_irq_n,
   input  logic              scan_done,
   input  logic [TIME_W-1:0] scan_interval_us,
   input  logic [TIME_W-1:0] scan_time_us,
   output logic              scan_trig,
   output logic              irq_masked
);
   generate
      if (CLKS_PER_US < 1) begin : g_bad_clk
         $error("pen_scan_trigger: CLKS_PER_US must be positive");
      end
      if (US_PER_MS < 1 || US_PER_MS > (1 << TIME_W)) begin : g_bad_ms
         $error("pen_scan_trigger: US_PER_MS out of range");
      end
      if (XCNT_W < 1) begin : g_bad_cnt
         $error("pen_scan_trigger: XCNT_W must be positive");
      end
   endgenerate

   logic              pen_act;
   logic              settle_pos;
   logic [TIME_W-1:0] settle_us;
   logic              settle_load, settle_cancel, settle_exp;
   logic              osh_load, osh_cancel, osh_exp;

   assign settle_pos = scan_interval_us > scan_time_us;
   assign settle_us  = scan_interval_us - scan_time_us;

   pst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din_n(pen_irq_n), .active(pen_act));

   pst_timer #(.CLKS_PER_US(CLKS_PER_US), .US_PER_MS(US_PER_MS),
               .W(TIME_W), .ROUND_MS(1'b0)) i_settle (
      .clk(clk), .rst_n(rst_n), .load(settle_load), .cancel(settle_cancel),
      .dur_us(settle_us), .expire(settle_exp));

   pst_timer #(.CLKS_PER_US(CLKS_PER_US), .US_PER_MS(US_PER_MS),
               .W(TIME_W), .ROUND_MS(1'b1)) i_oneshot (
      .clk(clk), .rst_n(rst_n), .load(osh_load), .cancel(osh_cancel),
      .dur_us(scan_interval_us), .expire(osh_exp));

   pst_ctrl #(.XCNT_W(XCNT_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pen_act(pen_act),
      .scan_done(scan_done), .settle_pos(settle_pos), .settle_exp(settle_exp),
      .osh_exp(osh_exp), .settle_load(settle_load), .settle_cancel(settle_cancel),
      .osh_load(osh_load), .osh_cancel(osh_cancel), .scan_trig(scan_trig),
      .irq_masked(irq_masked));
endmodule

// File: tb/test_pen_scan_trigger.sv
module test_pen_scan_trigger;
   localparam int C = 2;
   localparam int M = 5;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic pen_irq_n = 1'b1;
   logic scan_done = 1'b0;
   logic [W-1:0] ival = 12'd12;
   logic [W-1:0] tval = 12'd4;
   logic scan_trig, irq_masked;
   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   pen_scan_trigger #(.CLKS_PER_US(C), .US_PER_MS(M), .TIME_W(W)) i_pen_scan_trigger (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pen_irq_n(pen_irq_n),
      .scan_done(scan_done), .scan_interval_us(ival), .scan_time_us(tval),
      .scan_trig(scan_trig), .irq_masked(irq_masked));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         checks = checks + 1;
         fails = fails + 1;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_rearm(input int i, input int t);
      return (i > t) ? C * (i - t) + 1 : 0;
   endfunction

   function automatic int exp_tail(input int i);
      int ms;
      ms = (i == 0) ? 1 : (i + M - 1) / M;
      return C * ms * M + 1;
   endfunction

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_trig(input int lim, output int n);
      n = 0;
      while (!scan_trig && n < lim) begin
         @(negedge clk);
         n++;
      end
      if (!scan_trig) n = -1;
   endtask

   task automatic do_done(output int k);
      scan_done = 1'b1;
      @(negedge clk);
      scan_done = 1'b0;
      k = 0;
      while (irq_masked && k < 5000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic pen_trig(input string tag);
      int n;
      pen_irq_n = 1'b0;
      wait_trig(20, n);
      chk(n == 3, tag, n, 3);
      chk(irq_masked == 1'b1, {tag, " mask"}, irq_masked, 1);
   endtask

   initial begin
      int k, n, e;
      int iv, tv;
      void'($urandom(32'd4242));
      ticks(3);
      chk(irq_masked == 1'b1 && scan_trig == 1'b0, "R1 reset", {irq_masked, scan_trig}, 2);
      rst_n = 1'b1;
      ticks(2);
      pen_irq_n = 1'b0;
      wait_trig(20, n);
      chk(n == -1, "R1 disabled no trig", n, -1);
      chk(irq_masked == 1'b1, "R1 disabled masked", irq_masked, 1);
      pen_irq_n = 1'b1;
      ticks(4);

      enable = 1'b1;
      @(negedge clk);
      chk(irq_masked == 1'b0, "R2 enable unmasks", irq_masked, 0);

      pen_trig("R3 pen latency");
      @(negedge clk);
      chk(scan_trig == 1'b0, "R10 single pulse", scan_trig, 0);
      pen_irq_n = 1'b1;
      ticks(4);
      do_done(k);
      chk(k == exp_rearm(12, 4), "R5 settle wait", k, exp_rearm(12, 4));
      wait_trig(500, n);
      chk(n == exp_tail(12), "R6 trailing timer", n, exp_tail(12));

      do_done(k);
      chk(k == exp_rearm(12, 4), "R5 settle after tail", k, exp_rearm(12, 4));
      wait_trig(300, n);
      chk(n == -1, "R7 no timer after tail", n, -1);
      scan_done = 1'b1;
      @(negedge clk);
      scan_done = 1'b0;
      wait_trig(60, n);
      chk(n == -1 && irq_masked == 1'b0, "R5 stray done ignored", n, -1);

      pen_trig("R8 pen after tail");
      pen_irq_n = 1'b1;
      ticks(4);
      do_done(k);
      wait_trig(500, n);
      chk(n == exp_tail(12), "R8 count cleared", n, exp_tail(12));

      do_done(k);
      pen_trig("R8 pen start");
      pen_irq_n = 1'b1;
      ticks(4);
      do_done(k);
      ticks(10);
      pen_trig("R8 pen mid timer");
      pen_irq_n = 1'b1;
      ticks(4);
      do_done(k);
      wait_trig(500, n);
      chk(n == exp_tail(12), "R8 timer restarted", n, exp_tail(12));

      do_done(k);
      pen_trig("R4 setup");
      ticks(5);
      pen_irq_n = 1'b1;
      ticks(4);
      tval = 12'd20;
      do_done(k);
      chk(k == 0, "R5 non-positive diff", k, 0);
      wait_trig(500, n);
      chk(n == exp_tail(12), "R4 masked pen dropped", n, exp_tail(12));
      tval = 12'd4;
      do_done(k);

      ival = 12'd0;
      pen_trig("R6 zero interval setup");
      pen_irq_n = 1'b1;
      ticks(4);
      do_done(k);
      chk(k == 0, "R5 zero interval", k, 0);
      wait_trig(500, n);
      chk(n == exp_tail(0), "R6 zero interval tail", n, exp_tail(0));
      do_done(k);

      pen_trig("R9 hold start");
      for (int r = 0; r < 8; r++) begin
         iv = $urandom_range(30, 0);
         tv = $urandom_range(30, 0);
         ival = W'(iv);
         tval = W'(tv);
         do_done(k);
         e = exp_rearm(iv, tv);
         chk(k == e, "R5 random settle", k, e);
         chk(scan_trig == 1'b0, "R9 quiet at unmask", scan_trig, 0);
         @(negedge clk);
         chk(scan_trig == 1'b1, "R9 held retrigger", scan_trig, 1);
      end
      pen_irq_n = 1'b1;
      ticks(4);
      iv = $urandom_range(40, 1);
      ival = W'(iv);
      tval = 12'd0;
      do_done(k);
      chk(k == exp_rearm(iv, 0), "R5 random release", k, exp_rearm(iv, 0));
      wait_trig(1000, n);
      chk(n == exp_tail(iv), "R6 random tail", n, exp_tail(iv));
      do_done(k);

      ival = 12'd12;
      tval = 12'd4;
      pen_trig("R2 setup");
      pen_irq_n = 1'b1;
      ticks(4);
      do_done(k);
      ticks(6);
      enable = 1'b0;
      @(negedge clk);
      chk(irq_masked == 1'b1, "R2 disable masks", irq_masked, 1);
      ticks(3);
      enable = 1'b1;
      @(negedge clk);
      chk(irq_masked == 1'b0, "R2 re-enable", irq_masked, 0);
      wait_trig(300, n);
      chk(n == -1, "R2 timer cancelled", n, -1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule